// File: doc/BRIEF.md
# Parallel NOR Flash Bus Front End

This block sits behind the pins of a parallel NOR-style flash device. It samples the active-low chip select, read strobe, write strobe and hardware reset, along with a word/byte configuration select and a boot-sector write-protect input. From these it classifies every clock cycle as read, write, standby, output disable, reset or no-operation. The clock-synchronous model samples all pins once per clock. Every decision is taken on the sampled values.

Read cycles return data from a small internal word array. The 16 data lanes are not driven through tri-state buffers. Each lane has its own output-enable bit instead. Write cycles load the address and data into a command holding register, which has no address of its own. The command is acted on when the write strobe returns high. A small command tracker then decides whether the write was a program-setup code or program data.

In byte configuration, only the low eight lanes carry data. The top data pin acts as the lowest address bit and picks the half-word that is read or programmed.

Top module: `nor_bus_front`

## Requirements
- R1: With reset high, chip select low, read strobe low, write strobe high and word configuration (byteN high), the cycle after sampling drives all 16 lane enables high. dqOut carries the addressed word.
- R2: When chip select is sampled high, every lane enable is low in the following cycle.
- R3: With reset high, chip select low and both strobes high, every lane enable is low in the following cycle.
- R4: While the hardware reset pin is sampled low, every lane enable is low and all strobes are ignored. Leaving reset puts the command tracker back in read-array mode.
- R5: In byte configuration (byteN low), a read enables only lanes 7..0 (dqOe = 16'h00FF) and dqOut[15:8] is zero. dqIn[15] picks the byte: 1 selects bits 15..8 of the addressed word and 0 selects bits 7..0.
- R6: After power-on, the tracker is in read-array mode, so reads need no prior command. Word i initially holds {i[7:0] ^ 8'h3C, i[7:0] + 8'h81}.
- R7: A write whose low data byte is 8'hA0 arms programming and does not alter the array. The next completed write stores its data at its address. The write completes on the rising edge of the write strobe while chip select is low, and the stored values are those present while the strobe was low.
- R8: A byte-configuration program writes dqIn[7:0] into the half-word chosen by dqIn[15] and leaves the other half unchanged.
- R9: With wpN low, program data aimed at sector 0 or at the last sector is discarded. The sector is the top SECT_W bits of the word address. Any other sector, or any sector with wpN high, is programmed normally. Either way the tracker returns to read-array mode.
- R10: A cycle with both strobes low drives no lane and loads no command. An armed program is therefore still waiting for its data.
- R11: In read-array mode, a completed write whose low byte is not 8'hA0 changes neither the array nor the tracker.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| porN | input | 1 | Power-on reset, active low, synchronous; restores array contents and tracker |
| ceN | input | 1 | Chip select, active low |
| oeN | input | 1 | Read strobe / output gate, active low |
| weN | input | 1 | Write strobe, active low |
| rstPinN | input | 1 | Hardware reset pin, active low |
| byteN | input | 1 | 1 = word configuration, 0 = byte configuration |
| wpN | input | 1 | 0 = boot sectors write-protected |
| addr | input | ADDR_W | Word address |
| dqIn | input | 16 | Data lanes as seen from the bus; dqIn[15] is the byte address bit in byte configuration |
| dqOut | output | 16 | Read data for the lanes |
| dqOe | output | 16 | Per-lane output enable |

## Verification
A tracker left in program mode after a reset, or armed by the wrong code, shows up only on a later write. That write's data lands in the array, and the next read of that address returns it instead of the original word. The bench therefore follows every suspect write with a read. A wrong cycle classification appears one clock after the pins change, as stray lane enables. A wrong byte-lane mask appears as a corrupted neighbouring half-word on the read right after the program completes.

// File: rtl/nbf_pkg.sv
package nbf_pkg;

  localparam int DATA_W = 16;
  localparam logic [7:0] CMD_ARM_PROG = 8'hA0;

  typedef enum logic [2:0] {
    CYC_RESET,
    CYC_STANDBY,
    CYC_OUTDIS,
    CYC_READ,
    CYC_WRITE,
    CYC_NOP
  } cycle_e;

  typedef enum logic {
    TRK_READ,
    TRK_PROG
  } trk_e;

  typedef struct packed {
    logic drive;     // present array data on the lanes
    logic byteMode;  // sampled byte configuration
    logic loadCmd;   // capture address/data into command register
    logic progEn;    // commit command register into the array
  } strobe_t;

  function automatic logic [DATA_W-1:0] nbfInitWord(input int unsigned idx);
    logic [7:0] b;
    b = idx[7:0];
    return {b ^ 8'h3C, b + 8'h81};
  endfunction

endpackage

// File: rtl/nbf_ctrl.sv
module nbf_ctrl
  import nbf_pkg::*;
(
  input  logic       clk,
  input  logic       porN,
  input  logic       ceN,
  input  logic       oeN,
  input  logic       weN,
  input  logic       rstPinN,
  input  logic       byteN,
  input  logic       wpN,
  input  logic [7:0] cmdCode,
  input  logic       cmdBoot,
  output strobe_t    stb,
  output cycle_e     cycClass,
  output trk_e       trkState
);

  logic sCe, sOe, sWe, sRst, sByte, sWp;
  logic prevWrite;
  logic commit;
  logic blocked;

  // pin sampling
  always_ff @(posedge clk) begin
    if (!porN) begin
      sCe   <= 1'b1;
      sOe   <= 1'b1;
      sWe   <= 1'b1;
      sRst  <= 1'b0;
      sByte <= 1'b1;
      sWp   <= 1'b1;
    end else begin
      sCe   <= ceN;
      sOe   <= oeN;
      sWe   <= weN;
      sRst  <= rstPinN;
      sByte <= byteN;
      sWp   <= wpN;
    end
  end

  // cycle classification
  always_comb begin
    if (!sRst)             cycClass = CYC_RESET;
    else if (sCe)          cycClass = CYC_STANDBY;
    else if (!sOe && !sWe) cycClass = CYC_NOP;
    else if (!sOe)         cycClass = CYC_READ;
    else if (!sWe)         cycClass = CYC_WRITE;
    else                   cycClass = CYC_OUTDIS;
  end

  // remembers that the previous sample was a valid write phase
  always_ff @(posedge clk) begin
    if (!porN) prevWrite <= 1'b0;
    else       prevWrite <= (cycClass == CYC_WRITE);
  end

  assign commit  = prevWrite && sRst && !sCe && sWe;
  assign blocked = !sWp && cmdBoot;

  // command tracker
  always_ff @(posedge clk) begin
    if (!porN || !sRst) begin
      trkState <= TRK_READ;
    end else if (commit) begin
      case (trkState)
        TRK_READ: trkState <= (cmdCode == CMD_ARM_PROG) ? TRK_PROG : TRK_READ;
        default:  trkState <= TRK_READ;
      endcase
    end
  end

  always_comb begin
    stb.drive    = (cycClass == CYC_READ);
    stb.byteMode = !sByte;
    stb.loadCmd  = (cycClass == CYC_WRITE);
    stb.progEn   = commit && (trkState == TRK_PROG) && !blocked;
  end

endmodule

// File: rtl/nbf_datapath.sv
module nbf_datapath
  import nbf_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int SECT_W = 3
) (
  input  logic              clk,
  input  logic              porN,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] dqIn,
  input  strobe_t           stb,
  output logic [7:0]        cmdCode,
  output logic              cmdBoot,
  output logic [DATA_W-1:0] dqOut,
  output logic [DATA_W-1:0] dqOe
);

  localparam int DEPTH = 1 << ADDR_W;
  localparam logic [SECT_W-1:0] LAST_SECT = '1;

  logic [ADDR_W-1:0] sAddr;
  logic [DATA_W-1:0] sDq;

  logic [ADDR_W-1:0] cmdAddr;
  logic [DATA_W-1:0] cmdData;
  logic              cmdByteMode;
  logic              cmdByteSel;

  logic [DATA_W-1:0] mem [DEPTH];
  logic [1:0]        wrMask;
  logic [DATA_W-1:0] wrData;
  logic [SECT_W-1:0] cmdSect;
  logic [DATA_W-1:0] rdWord;

  always_ff @(posedge clk) begin
    if (!porN) begin
      sAddr <= '0;
      sDq   <= '0;
    end else begin
      sAddr <= addr;
      sDq   <= dqIn;
    end
  end

  // command register: not addressable, loaded during write phase
  always_ff @(posedge clk) begin
    if (!porN) begin
      cmdAddr     <= '0;
      cmdData     <= '0;
      cmdByteMode <= 1'b0;
      cmdByteSel  <= 1'b0;
    end else if (stb.loadCmd) begin
      cmdAddr     <= sAddr;
      cmdData     <= sDq;
      cmdByteMode <= stb.byteMode;
      cmdByteSel  <= sDq[DATA_W-1];
    end
  end

  assign cmdCode = cmdData[7:0];
  assign cmdSect = cmdAddr[ADDR_W-1 -: SECT_W];
  assign cmdBoot = (cmdSect == '0) || (cmdSect == LAST_SECT);

  always_comb begin
    if (cmdByteMode) begin
      wrMask = cmdByteSel ? 2'b10 : 2'b01;
      wrData = {cmdData[7:0], cmdData[7:0]};
    end else begin
      wrMask = 2'b11;
      wrData = cmdData;
    end
  end

  // word array, one register row per word, two byte lanes each
  for (genvar w = 0; w < DEPTH; w++) begin : g_word
    for (genvar ln = 0; ln < 2; ln++) begin : g_lane
      localparam logic [DATA_W-1:0] INITW = nbfInitWord(w);
      always_ff @(posedge clk) begin
        if (!porN)
          mem[w][ln*8 +: 8] <= INITW[ln*8 +: 8];
        else if (stb.progEn && wrMask[ln] && (cmdAddr == ADDR_W'(w)))
          mem[w][ln*8 +: 8] <= wrData[ln*8 +: 8];
      end
    end
  end

  assign rdWord = mem[sAddr];

  always_comb begin
    dqOut = '0;
    dqOe  = '0;
    if (stb.drive) begin
      if (stb.byteMode) begin
        dqOut = {8'h00, sDq[DATA_W-1] ? rdWord[15:8] : rdWord[7:0]};
        dqOe  = 16'h00FF;
      end else begin
        dqOut = rdWord;
        dqOe  = '1;
      end
    end
  end

endmodule

// File: rtl/nor_bus_front.sv
module nor_bus_front
  import nbf_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int SECT_W = 3
) (
  input  logic              clk,
  input  logic              porN,
  input  logic              ceN,
  input  logic              oeN,
  input  logic              weN,
  input  logic              rstPinN,
  input  logic              byteN,
  input  logic              wpN,
  input  logic [ADDR_W-1:0] addr,
  input  logic [15:0]       dqIn,
  output logic [15:0]       dqOut,
  output logic [15:0]       dqOe
);

  strobe_t    stb;
  cycle_e     cycClass;
  trk_e       trkState;
  logic [7:0] cmdCode;
  logic       cmdBoot;

  nbf_ctrl u_ctrl (
    .clk      (clk),
    .porN     (porN),
    .ceN      (ceN),
    .oeN      (oeN),
    .weN      (weN),
    .rstPinN  (rstPinN),
    .byteN    (byteN),
    .wpN      (wpN),
    .cmdCode  (cmdCode),
    .cmdBoot  (cmdBoot),
    .stb      (stb),
    .cycClass (cycClass),
    .trkState (trkState)
  );

  nbf_datapath #(
    .ADDR_W (ADDR_W),
    .SECT_W (SECT_W)
  ) u_dp (
    .clk     (clk),
    .porN    (porN),
    .addr    (addr),
    .dqIn    (dqIn),
    .stb     (stb),
    .cmdCode (cmdCode),
    .cmdBoot (cmdBoot),
    .dqOut   (dqOut),
    .dqOe    (dqOe)
  );

endmodule

// File: rtl/nbf_checker.sv
module nbf_checker (
  input logic        clk,
  input logic        porN,
  input logic        ceN,
  input logic        oeN,
  input logic        weN,
  input logic        rstPinN,
  input logic        byteN,
  input logic [15:0] dqOut,
  input logic [15:0] dqOe
);

  p_word_read_lanes_r1: assert property (@(posedge clk) disable iff (!porN)
    $past(porN && rstPinN && !ceN && !oeN && weN && byteN) |-> (dqOe == 16'hFFFF));

  p_standby_float_r2: assert property (@(posedge clk) disable iff (!porN)
    $past(ceN) |-> (dqOe == 16'h0000));

  p_outdis_float_r3: assert property (@(posedge clk) disable iff (!porN)
    $past(rstPinN && !ceN && oeN && weN) |-> (dqOe == 16'h0000));

  p_reset_float_r4: assert property (@(posedge clk) disable iff (!porN)
    $past(!rstPinN) |-> (dqOe == 16'h0000));

  p_byte_read_lanes_r5: assert property (@(posedge clk) disable iff (!porN)
    $past(porN && rstPinN && !ceN && !oeN && weN && !byteN)
      |-> (dqOe == 16'h00FF && dqOut[15:8] == 8'h00));

  p_nop_float_r10: assert property (@(posedge clk) disable iff (!porN)
    $past(!oeN && !weN) |-> (dqOe == 16'h0000));

endmodule

bind nor_bus_front nbf_checker u_chk (
  .clk     (clk),
  .porN    (porN),
  .ceN     (ceN),
  .oeN     (oeN),
  .weN     (weN),
  .rstPinN (rstPinN),
  .byteN   (byteN),
  .dqOut   (dqOut),
  .dqOe    (dqOe)
);

// File: tb/tb_nor_bus_front.sv
module tb_nor_bus_front;

  localparam int AW = 6;
  localparam int DEPTH = 1 << AW;

  logic          clk = 1'b0;
  logic          porN, ceN, oeN, weN, rstPinN, byteN, wpN;
  logic [AW-1:0] addr;
  logic [15:0]   dqIn;
  logic [15:0]   dqOut, dqOe;

  int total = 0;
  int bad = 0;
  logic [15:0] model [DEPTH];

  always #2 clk = ~clk;

  nor_bus_front #(.ADDR_W(AW), .SECT_W(3)) dut (
    .clk(clk), .porN(porN), .ceN(ceN), .oeN(oeN), .weN(weN),
    .rstPinN(rstPinN), .byteN(byteN), .wpN(wpN), .addr(addr),
    .dqIn(dqIn), .dqOut(dqOut), .dqOe(dqOe)
  );

  function automatic logic [15:0] initVal(input int i);
    logic [7:0] b;
    b = 8'(i);
    return {b ^ 8'h3C, b + 8'h81};
  endfunction

  task automatic check(input string req, input string what,
                       input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic idle();
    ceN = 1'b1; oeN = 1'b1; weN = 1'b1;
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic busRead(input logic [AW-1:0] a, input logic bm, input logic hi,
                         output logic [15:0] d, output logic [15:0] oe);
    ceN = 1'b0; oeN = 1'b0; weN = 1'b1; byteN = ~bm; addr = a;
    dqIn = {hi, 15'h0};
    tick(1);
    d = dqOut; oe = dqOe;
    idle();
    tick(1);
  endtask

  task automatic busWrite(input logic [AW-1:0] a, input logic [15:0] d,
                          input logic bm);
    ceN = 1'b0; oeN = 1'b1; weN = 1'b0; byteN = ~bm; addr = a; dqIn = d;
    tick(1);
    weN = 1'b1;
    tick(1);
    idle();
    tick(2);
  endtask

  task automatic expectWord(input string req, input int a);
    logic [15:0] d, oe;
    busRead(AW'(a), 1'b0, 1'b0, d, oe);
    check(req, $sformatf("word @%0d", a), d, model[a]);
    check(req, "word lanes", oe, 16'hFFFF);
  endtask

  task automatic t_powerup();
    tick(1);
    check("R2", "idle lanes", dqOe, 16'h0000);
    foreach (model[i]) model[i] = initVal(i);
    expectWord("R6", 0);
    expectWord("R1", 17);
    expectWord("R6", 63);
  endtask

  task automatic t_float();
    ceN = 1'b1; oeN = 1'b0; weN = 1'b1; tick(1);
    check("R2", "standby with read strobe", dqOe, 16'h0000);
    ceN = 1'b0; oeN = 1'b1; weN = 1'b1; tick(1);
    check("R3", "output disable", dqOe, 16'h0000);
    idle(); tick(1);
  endtask

  task automatic t_program();
    busWrite(6'd9, 16'h00A0, 1'b0);
    expectWord("R7", 9);
    busWrite(6'd9, 16'hBEEF, 1'b0);
    model[9] = 16'hBEEF;
    expectWord("R7", 9);
    busWrite(6'd11, 16'h1234, 1'b0);
    busWrite(6'd11, 16'h4321, 1'b0);
    expectWord("R11", 11);
  endtask

  task automatic t_byte();
    logic [15:0] d, oe;
    busRead(6'd12, 1'b1, 1'b0, d, oe);
    check("R5", "low byte", d, {8'h00, model[12][7:0]});
    check("R5", "byte lanes", oe, 16'h00FF);
    busRead(6'd12, 1'b1, 1'b1, d, oe);
    check("R5", "high byte", d, {8'h00, model[12][15:8]});
    busWrite(6'd12, 16'h00A0, 1'b1);
    busWrite(6'd12, 16'h805C, 1'b1);
    model[12][15:8] = 8'h5C;
    expectWord("R8", 12);
    busWrite(6'd13, 16'h00A0, 1'b1);
    busWrite(6'd13, 16'h0077, 1'b1);
    model[13][7:0] = 8'h77;
    expectWord("R8", 13);
  endtask

  task automatic t_protect();
    wpN = 1'b0;
    busWrite(6'd2, 16'h00A0, 1'b0);
    busWrite(6'd2, 16'h1111, 1'b0);
    expectWord("R9", 2);
    busWrite(6'd63, 16'h00A0, 1'b0);
    busWrite(6'd63, 16'h2222, 1'b0);
    expectWord("R9", 63);
    busWrite(6'd63, 16'h3333, 1'b0);
    expectWord("R9", 63);
    busWrite(6'd20, 16'h00A0, 1'b0);
    busWrite(6'd20, 16'h4444, 1'b0);
    model[20] = 16'h4444;
    expectWord("R9", 20);
    wpN = 1'b1;
    busWrite(6'd3, 16'h00A0, 1'b0);
    busWrite(6'd3, 16'h5555, 1'b0);
    model[3] = 16'h5555;
    expectWord("R9", 3);
  endtask

  task automatic t_nop();
    busWrite(6'd30, 16'h00A0, 1'b0);
    ceN = 1'b0; oeN = 1'b0; weN = 1'b0; byteN = 1'b1; addr = 6'd31;
    dqIn = 16'h9999;
    tick(1);
    check("R10", "both strobes low lanes", dqOe, 16'h0000);
    weN = 1'b1; oeN = 1'b1;
    tick(1);
    idle(); tick(2);
    expectWord("R10", 31);
    busWrite(6'd30, 16'h7777, 1'b0);
    model[30] = 16'h7777;
    expectWord("R10", 30);
  endtask

  task automatic t_hwreset();
    busWrite(6'd40, 16'h00A0, 1'b0);
    rstPinN = 1'b0;
    ceN = 1'b0; oeN = 1'b0; weN = 1'b1; addr = 6'd40;
    tick(1);
    check("R4", "reset lanes", dqOe, 16'h0000);
    oeN = 1'b1; weN = 1'b0; dqIn = 16'h6666;
    tick(1);
    weN = 1'b1; tick(1);
    check("R4", "reset lanes late", dqOe, 16'h0000);
    idle(); rstPinN = 1'b1; tick(2);
    busWrite(6'd40, 16'h4444, 1'b0);
    expectWord("R4", 40);
  endtask

  initial begin
    #800000;
    bad++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    porN = 1'b0; rstPinN = 1'b1; byteN = 1'b1; wpN = 1'b1;
    addr = '0; dqIn = '0;
    idle();
    tick(3);
    porN = 1'b1;
    t_powerup();
    t_float();
    t_program();
    t_byte();
    t_protect();
    t_nop();
    t_hwreset();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule